// File: doc/BRIEF.md
# Burst-Mode Protocol Monitor

This block is a clocked observer placed beside a burst-mode controller. It samples the controller's input and output wires once per clock and checks them against a table of arcs fixed at elaboration. Each arc names a source state, the set of input edges that make up its input burst, a destination state and the set of output edges that make up its output burst. The monitor tracks the specified state. It accepts the edges of an input burst in any order, one at a time or several in the same sample. It moves to the next state only once the whole burst is present. It then waits until every edge of the resulting output burst has been seen before it lets any input move again.

The first violation sets a sticky error flag with a code. It also latches the index of the last arc taken and the cycle count since reset. From then on, tracking freezes until the next synchronous reset. The arc table is also screened at elaboration: an empty burst, or two arcs from one state where one burst is contained in the other, is reported as soon as reset is released.

Top module: `burst_protocol_monitor`

## Requirements
- R1: After synchronous reset, errFlag is 0 and errCode is 0. specState equals INIT_STATE (0 by default) and specPending is 0. All watched inputs and outputs are taken to have been 0 at reset.
- R2: A partly complete input burst leaves specState unchanged. When every edge of an arc's input burst is present, in any order or all in one sample, specState shows that arc's destination state from the next cycle.
- R3: After an arc whose output burst is not empty, specPending is 1 until every listed output edge has been seen, in any order. After the last one, it returns to 0 in the next cycle. An arc with an empty output burst leaves specPending at 0.
- R4: While specPending is 0, an input edge that no arc leaving the current state allows in that direction sets error code 1. An input that returns to its value at burst start also sets code 1.
- R5: An output edge outside the pending output burst sets error code 2. This covers any output edge while specPending is 0, including an output edge in the same sample as the input that completes a burst.
- R6: Any input edge while specPending is 1 sets error code 3. This includes the sample in which the last pending output edge arrives.
- R7: errFlag is sticky. errCode, errArc, errCycle, specState and specPending keep the values of the first violation until reset, even if more violations follow.
- R8: errArc holds the index of the last arc taken before the violation, or NUM_ARC if none was taken. errCycle holds the number of clock cycles since reset was released, counting the first sampled cycle as 0.
- R9: If the arc table has an empty input burst, or two arcs from one state where one input burst is a subset of (or equal to) the other, errFlag rises with code 4 in the first cycle after reset. errCycle is then 0.
- R10: When an input violation (code 1 or 3) and an output violation happen in the same sample, the input code is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ctlIn | input | 8 | Input wires of the watched controller |
| ctlOut | input | 8 | Output wires of the watched controller |
| errFlag | output | 1 | Sticky violation flag |
| errCode | output | 3 | 0 none, 1 stray input, 2 stray output, 3 early input, 4 bad table |
| errArc | output | ARC_W | Last arc taken before the first violation (NUM_ARC if none) |
| errCycle | output | CYC_W | Cycle of the first violation |
| specState | output | 3 | Tracked specification state |
| specPending | output | 1 | An output burst is still outstanding |

## Verification
A corrupted tracked state or burst origin shows on specState or specPending one cycle after the sample that caused it. It may also show a cycle later as a spurious error flag on the next legal edge, or as a missing flag on an illegal one. Lost output-burst bookkeeping shows as specPending dropping early or hanging. It also shows as a wrong code 2 or 3 on the following edge. Each step of the bench therefore compares state, pending, flag and code one cycle after the stimulus. Error steps also compare the latched arc and cycle.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

  localparam int SIG_W = 8;
  localparam int ST_W  = 3;

  typedef struct packed {
    logic [ST_W-1:0]  srcState;
    logic [SIG_W-1:0] inRise;
    logic [SIG_W-1:0] inFall;
    logic [ST_W-1:0]  dstState;
    logic [SIG_W-1:0] outRise;
    logic [SIG_W-1:0] outFall;
  } arc_t;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_IN_STRAY  = 3'd1,
    ERR_OUT_STRAY = 3'd2,
    ERR_IN_EARLY  = 3'd3,
    ERR_SPEC      = 3'd4
  } err_e;

  typedef enum logic {
    PH_COLLECT = 1'b0,
    PH_DRAIN   = 1'b1
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeArc;
    logic trackEdges;
    logic updatePend;
  } dp_ctl_t;

  function automatic arc_t mkArc(input logic [ST_W-1:0] src,
                                 input logic [SIG_W-1:0] rr,
                                 input logic [SIG_W-1:0] ff,
                                 input logic [ST_W-1:0] dst,
                                 input logic [SIG_W-1:0] orr,
                                 input logic [SIG_W-1:0] off);
    arc_t a;
    a.srcState = src;
    a.inRise   = rr;
    a.inFall   = ff;
    a.dstState = dst;
    a.outRise  = orr;
    a.outFall  = off;
    return a;
  endfunction

  localparam int DEFAULT_NUM_ARC = 6;

  // index 0 is the rightmost element
  localparam arc_t [DEFAULT_NUM_ARC-1:0] DEFAULT_ARCS = {
    mkArc(3'd3, 8'h00, 8'h0B, 3'd0, 8'h00, 8'h01),
    mkArc(3'd1, 8'h08, 8'h00, 3'd3, 8'h00, 8'h00),
    mkArc(3'd2, 8'h00, 8'h04, 3'd0, 8'h00, 8'h06),
    mkArc(3'd0, 8'h04, 8'h00, 3'd2, 8'h06, 8'h00),
    mkArc(3'd1, 8'h00, 8'h03, 3'd0, 8'h00, 8'h01),
    mkArc(3'd0, 8'h03, 8'h00, 3'd1, 8'h01, 8'h00)
  };

endpackage

// File: rtl/bpm_datapath.sv
module bpm_datapath
  import bpm_pkg::*;
#(
  parameter int                  NUM_ARC = DEFAULT_NUM_ARC,
  parameter arc_t [NUM_ARC-1:0]  ARCS    = DEFAULT_ARCS,
  parameter int                  ARC_W   = $clog2(NUM_ARC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SIG_W-1:0] ctlIn,
  input  logic [SIG_W-1:0] ctlOut,
  input  logic [ST_W-1:0]  curState,
  input  dp_ctl_t          ctl,
  output logic             specBad,
  output logic             strayIn,
  output logic             strayOut,
  output logic             anyInEdge,
  output logic             arcHit,
  output logic [ARC_W-1:0] hitIdx,
  output logic [ST_W-1:0]  hitDst,
  output logic             hitHasOut,
  output logic             pendClears
);

  // table screening: empty burst, conflicting edges, or a burst contained in another
  function automatic logic tableBad(input arc_t [NUM_ARC-1:0] t);
    logic bad;
    bad = 1'b0;
    for (int a = 0; a < NUM_ARC; a++) begin
      if ((t[a].inRise | t[a].inFall) == '0) bad = 1'b1;
      if ((t[a].inRise & t[a].inFall) != '0) bad = 1'b1;
      for (int b = 0; b < NUM_ARC; b++) begin
        if (a != b && t[a].srcState == t[b].srcState &&
            (t[a].inRise & ~t[b].inRise) == '0 &&
            (t[a].inFall & ~t[b].inFall) == '0)
          bad = 1'b1;
      end
    end
    return bad;
  endfunction

  localparam logic SPEC_BAD = tableBad(ARCS);

  logic [SIG_W-1:0] prevIn;
  logic [SIG_W-1:0] prevOut;
  logic [SIG_W-1:0] burstBase;
  logic [SIG_W-1:0] pendRise;
  logic [SIG_W-1:0] pendFall;

  logic [SIG_W-1:0] inDelta;
  logic [SIG_W-1:0] outDelta;
  logic [SIG_W-1:0] riseSeen;
  logic [SIG_W-1:0] fallSeen;
  logic [SIG_W-1:0] allowAll;
  logic [SIG_W-1:0] selOutRise;
  logic [SIG_W-1:0] selOutFall;
  logic [SIG_W-1:0] arcAllow [NUM_ARC];
  logic [NUM_ARC-1:0] arcDone;

  assign inDelta  = ctlIn ^ prevIn;
  assign outDelta = ctlOut ^ prevOut;

  // per-arc evaluation against the input values at burst start
  for (genvar g = 0; g < NUM_ARC; g++) begin : g_arc
    localparam arc_t A = ARCS[g];
    logic srcMatch;
    logic [SIG_W-1:0] burstMask;
    assign burstMask   = A.inRise | A.inFall;
    assign srcMatch    = (curState == A.srcState);
    assign arcAllow[g] = srcMatch ? ((A.inRise & ~burstBase) | (A.inFall & burstBase))
                                  : '0;
    assign arcDone[g]  = srcMatch &&
                         (ctlIn == (burstBase ^ burstMask)) &&
                         ((A.inRise & burstBase) == '0) &&
                         ((A.inFall & ~burstBase) == '0);
  end

  always_comb begin
    allowAll = '0;
    for (int k = 0; k < NUM_ARC; k++) allowAll = allowAll | arcAllow[k];
  end

  // lowest completed arc wins; a valid table never completes two at once
  always_comb begin
    arcHit     = 1'b0;
    hitIdx     = '0;
    hitDst     = '0;
    selOutRise = '0;
    selOutFall = '0;
    for (int k = NUM_ARC - 1; k >= 0; k--) begin
      if (arcDone[k]) begin
        arcHit     = 1'b1;
        hitIdx     = ARC_W'(k);
        hitDst     = ARCS[k].dstState;
        selOutRise = ARCS[k].outRise;
        selOutFall = ARCS[k].outFall;
      end
    end
  end

  assign hitHasOut = |(selOutRise | selOutFall);

  // an input edge is stray if it reverts or is not allowed in its direction
  assign strayIn   = |(inDelta & ((prevIn ^ burstBase) | ~allowAll));
  assign anyInEdge = |inDelta;

  assign riseSeen   = outDelta & ctlOut & pendRise;
  assign fallSeen   = outDelta & ~ctlOut & pendFall;
  assign strayOut   = |(outDelta & ~(riseSeen | fallSeen));
  assign pendClears = ((pendRise & ~riseSeen) | (pendFall & ~fallSeen)) == '0;
  assign specBad    = SPEC_BAD;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevIn    <= '0;
      prevOut   <= '0;
      burstBase <= '0;
      pendRise  <= '0;
      pendFall  <= '0;
    end else begin
      if (ctl.trackEdges) begin
        prevIn  <= ctlIn;
        prevOut <= ctlOut;
      end
      if (ctl.takeArc) begin
        burstBase <= ctlIn;
        pendRise  <= selOutRise;
        pendFall  <= selOutFall;
      end else if (ctl.updatePend) begin
        pendRise <= pendRise & ~riseSeen;
        pendFall <= pendFall & ~fallSeen;
      end
    end
  end

endmodule

// File: rtl/bpm_control.sv
module bpm_control
  import bpm_pkg::*;
#(
  parameter int              NUM_ARC    = DEFAULT_NUM_ARC,
  parameter int              ARC_W      = $clog2(NUM_ARC + 1),
  parameter int              CYC_W      = 16,
  parameter logic [ST_W-1:0] INIT_STATE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             specBad,
  input  logic             strayIn,
  input  logic             strayOut,
  input  logic             anyInEdge,
  input  logic             arcHit,
  input  logic [ARC_W-1:0] hitIdx,
  input  logic [ST_W-1:0]  hitDst,
  input  logic             hitHasOut,
  input  logic             pendClears,
  output dp_ctl_t          ctl,
  output logic [ST_W-1:0]  curState,
  output logic             pending,
  output logic             errFlag,
  output err_e             errCode,
  output logic [ARC_W-1:0] errArc,
  output logic [CYC_W-1:0] errCycle
);

  localparam logic [ARC_W-1:0] NONE_ARC = ARC_W'(NUM_ARC);

  phase_e           phase;
  logic [ARC_W-1:0] lastArc;
  logic [CYC_W-1:0] cycleCnt;
  logic             live;
  logic             inViol;
  logic             violNow;
  err_e             violCode;

  assign live    = !errFlag;
  assign pending = (phase == PH_DRAIN);

  always_comb begin
    inViol  = (phase == PH_COLLECT) ? strayIn : anyInEdge;
    violNow = specBad | inViol | strayOut;
    if (specBad)
      violCode = ERR_SPEC;
    else if (inViol)
      violCode = (phase == PH_COLLECT) ? ERR_IN_STRAY : ERR_IN_EARLY;
    else
      violCode = ERR_OUT_STRAY;
  end

  always_comb begin
    ctl.trackEdges = live;
    ctl.takeArc    = live && !violNow && (phase == PH_COLLECT) && arcHit;
    ctl.updatePend = live && !violNow && (phase == PH_DRAIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curState <= INIT_STATE;
      phase    <= PH_COLLECT;
      errFlag  <= 1'b0;
      errCode  <= ERR_NONE;
      errArc   <= NONE_ARC;
      errCycle <= '0;
      lastArc  <= NONE_ARC;
      cycleCnt <= '0;
    end else begin
      if (cycleCnt != '1) cycleCnt <= cycleCnt + 1'b1;
      if (live) begin
        if (violNow) begin
          errFlag  <= 1'b1;
          errCode  <= violCode;
          errArc   <= lastArc;
          errCycle <= cycleCnt;
        end else if (phase == PH_COLLECT && arcHit) begin
          curState <= hitDst;
          lastArc  <= hitIdx;
          phase    <= hitHasOut ? PH_DRAIN : PH_COLLECT;
        end else if (phase == PH_DRAIN && pendClears) begin
          phase <= PH_COLLECT;
        end
      end
    end
  end

endmodule

// File: rtl/burst_protocol_monitor.sv
module burst_protocol_monitor
  import bpm_pkg::*;
#(
  parameter int                 NUM_ARC    = DEFAULT_NUM_ARC,
  parameter arc_t [NUM_ARC-1:0] ARCS       = DEFAULT_ARCS,
  parameter logic [ST_W-1:0]    INIT_STATE = '0,
  parameter int                 CYC_W      = 16,
  localparam int                ARC_W      = $clog2(NUM_ARC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SIG_W-1:0] ctlIn,
  input  logic [SIG_W-1:0] ctlOut,
  output logic             errFlag,
  output logic [2:0]       errCode,
  output logic [ARC_W-1:0] errArc,
  output logic [CYC_W-1:0] errCycle,
  output logic [ST_W-1:0]  specState,
  output logic             specPending
);

  dp_ctl_t          ctl;
  logic             specBad;
  logic             strayIn;
  logic             strayOut;
  logic             anyInEdge;
  logic             arcHit;
  logic [ARC_W-1:0] hitIdx;
  logic [ST_W-1:0]  hitDst;
  logic             hitHasOut;
  logic             pendClears;
  err_e             errCodeE;

  bpm_datapath #(.NUM_ARC(NUM_ARC), .ARCS(ARCS), .ARC_W(ARC_W)) u_datapath (
    .clk(clk), .rst(rst), .ctlIn(ctlIn), .ctlOut(ctlOut), .curState(specState),
    .ctl(ctl), .specBad(specBad), .strayIn(strayIn), .strayOut(strayOut),
    .anyInEdge(anyInEdge), .arcHit(arcHit), .hitIdx(hitIdx), .hitDst(hitDst),
    .hitHasOut(hitHasOut), .pendClears(pendClears)
  );

  bpm_control #(.NUM_ARC(NUM_ARC), .ARC_W(ARC_W), .CYC_W(CYC_W),
                .INIT_STATE(INIT_STATE)) u_control (
    .clk(clk), .rst(rst), .specBad(specBad), .strayIn(strayIn),
    .strayOut(strayOut), .anyInEdge(anyInEdge), .arcHit(arcHit),
    .hitIdx(hitIdx), .hitDst(hitDst), .hitHasOut(hitHasOut),
    .pendClears(pendClears), .ctl(ctl), .curState(specState),
    .pending(specPending), .errFlag(errFlag), .errCode(errCodeE),
    .errArc(errArc), .errCycle(errCycle)
  );

  assign errCode = errCodeE;

endmodule

// File: rtl/bpm_checker.sv
module bpm_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] ctlIn,
  input logic [7:0] ctlOut,
  input logic       errFlag,
  input logic [2:0] errCode,
  input logic [2:0] specState,
  input logic       specPending
);

  logic [7:0] prevInC;
  logic [7:0] prevOutC;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen     <= 1'b0;
      prevInC  <= '0;
      prevOutC <= '0;
    end else begin
      seen     <= 1'b1;
      prevInC  <= ctlIn;
      prevOutC <= ctlOut;
    end
  end

  // R1
  code_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !errFlag |-> errCode == 3'd0);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> $stable(errCode) && $stable(specState) && $stable(specPending));

  // R6
  early_input_chk: assert property (@(posedge clk) disable iff (rst)
    seen && specPending && !errFlag && (ctlIn != prevInC) |=> errFlag && errCode == 3'd3);

  // R5
  idle_output_chk: assert property (@(posedge clk) disable iff (rst)
    seen && !specPending && !errFlag && (ctlOut != prevOutC) |=> errFlag);

endmodule

bind burst_protocol_monitor bpm_checker u_bpmChk (
  .clk(clk), .rst(rst), .ctlIn(ctlIn), .ctlOut(ctlOut), .errFlag(errFlag),
  .errCode(errCode), .specState(specState), .specPending(specPending)
);

// File: tb/burst_protocol_monitor_bench.sv
module burst_protocol_monitor_bench;
  import bpm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_ARC    = DEFAULT_NUM_ARC;
  localparam int ARC_W      = $clog2(NUM_ARC + 1);
  localparam int CYC_W      = 16;
  localparam int NONE       = NUM_ARC;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       ctlIn = '0;
  logic [7:0]       ctlOut = '0;
  logic             errFlag;
  logic [2:0]       errCode;
  logic [ARC_W-1:0] errArc;
  logic [CYC_W-1:0] errCycle;
  logic [2:0]       specState;
  logic             specPending;

  logic             badFlag;
  logic [2:0]       badCode;
  logic [1:0]       badArc;
  logic [CYC_W-1:0] badCycle;
  logic [2:0]       badState;
  logic             badPending;

  localparam arc_t [1:0] BAD_ARCS = {
    mkArc(3'd0, 8'h03, 8'h00, 3'd1, 8'h01, 8'h00),
    mkArc(3'd0, 8'h01, 8'h00, 3'd2, 8'h02, 8'h00)
  };

  burst_protocol_monitor u_burst_protocol_monitor (
    .clk(clk), .rst(rst), .ctlIn(ctlIn), .ctlOut(ctlOut), .errFlag(errFlag),
    .errCode(errCode), .errArc(errArc), .errCycle(errCycle),
    .specState(specState), .specPending(specPending)
  );

  burst_protocol_monitor #(.NUM_ARC(2), .ARCS(BAD_ARCS)) u_badSpec (
    .clk(clk), .rst(rst), .ctlIn(8'h00), .ctlOut(8'h00), .errFlag(badFlag),
    .errCode(badCode), .errArc(badArc), .errCycle(badCycle),
    .specState(badState), .specPending(badPending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic       eFlag;
    logic [2:0] eCode;
    logic [2:0] eState;
    logic       ePend;
    logic       eDbg;
    logic [7:0] eArc;
    logic [15:0] eCyc;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  exp_t  monItem;
  string monTag;
  int    nChecks = 0;
  int    nErrors = 0;
  int    stepNo  = 0;
  bit    done    = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expectation per clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (expQ.size() > 0) begin
      monItem = expQ.pop_front();
      monTag  = tagQ.pop_front();
      check(errFlag == monItem.eFlag, monTag, "errFlag", int'(errFlag), int'(monItem.eFlag));
      check(errCode == monItem.eCode, monTag, "errCode", int'(errCode), int'(monItem.eCode));
      check(specState == monItem.eState, monTag, "specState", int'(specState), int'(monItem.eState));
      check(specPending == monItem.ePend, monTag, "specPending", int'(specPending), int'(monItem.ePend));
      if (monItem.eDbg) begin
        check(int'(errArc) == int'(monItem.eArc), monTag, "errArc", int'(errArc), int'(monItem.eArc));
        check(int'(errCycle) == int'(monItem.eCyc), monTag, "errCycle", int'(errCycle), int'(monItem.eCyc));
      end
    end
  end

  // driver: apply one sample at a falling edge and queue its expected result
  task automatic step(input logic [7:0] i, input logic [7:0] o,
                      input logic eF, input logic [2:0] eC, input logic [2:0] eS,
                      input logic eP, input logic eD, input int eA, input int eCy,
                      input string tag);
    exp_t e;
    ctlIn  = i;
    ctlOut = o;
    e.eFlag = eF; e.eCode = eC; e.eState = eS; e.ePend = eP;
    e.eDbg = eD; e.eArc = 8'(eA); e.eCyc = 16'(eCy);
    expQ.push_back(e);
    tagQ.push_back(tag);
    stepNo++;
    @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    ctlIn = '0;
    ctlOut = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    stepNo = 0;
    check(errFlag == 1'b0, "R1", "reset errFlag", int'(errFlag), 0);
    check(errCode == 3'd0, "R1", "reset errCode", int'(errCode), 0);
    check(specState == 3'd0, "R1", "reset specState", int'(specState), 0);
    check(specPending == 1'b0, "R1", "reset specPending", int'(specPending), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    doReset();
    // legal traffic through every arc
    step(8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(8'h01, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(8'h03, 8'h00, 0, 0, 1, 1, 0, 0, 0, "R2");
    step(8'h03, 8'h01, 0, 0, 1, 0, 0, 0, 0, "R3");
    step(8'h02, 8'h01, 0, 0, 1, 0, 0, 0, 0, "R2");
    step(8'h00, 8'h01, 0, 0, 0, 1, 0, 0, 0, "R2");
    step(8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(8'h04, 8'h00, 0, 0, 2, 1, 0, 0, 0, "R2");
    step(8'h04, 8'h02, 0, 0, 2, 1, 0, 0, 0, "R3");
    step(8'h04, 8'h06, 0, 0, 2, 0, 0, 0, 0, "R3");
    step(8'h00, 8'h06, 0, 0, 0, 1, 0, 0, 0, "R2");
    step(8'h00, 8'h04, 0, 0, 0, 1, 0, 0, 0, "R3");
    step(8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(8'h03, 8'h00, 0, 0, 1, 1, 0, 0, 0, "R2");
    step(8'h03, 8'h01, 0, 0, 1, 0, 0, 0, 0, "R3");
    step(8'h0B, 8'h01, 0, 0, 3, 0, 0, 0, 0, "R3");
    step(8'h0A, 8'h01, 0, 0, 3, 0, 0, 0, 0, "R2");
    step(8'h08, 8'h01, 0, 0, 3, 0, 0, 0, 0, "R2");
    step(8'h00, 8'h01, 0, 0, 0, 1, 0, 0, 0, "R2");
    step(8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R9: the second instance holds a subset-conflicting table
    check(badFlag == 1'b1, "R9", "bad table flag", int'(badFlag), 1);
    check(badCode == 3'd4, "R9", "bad table code", int'(badCode), 4);
    check(badCycle == '0, "R9", "bad table cycle", int'(badCycle), 0);

    doReset();  // R4 reverting input
    step(8'h01, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(8'h00, 8'h00, 1, 1, 0, 0, 1, NONE, 1, "R4");

    doReset();  // R4 unnamed input, then R7 stickiness
    step(8'h10, 8'h00, 1, 1, 0, 0, 1, NONE, 0, "R4");
    step(8'h10, 8'h01, 1, 1, 0, 0, 1, NONE, 0, "R7");
    step(8'h00, 8'h00, 1, 1, 0, 0, 1, NONE, 0, "R7");

    doReset();  // R5 output while idle
    step(8'h00, 8'h01, 1, 2, 0, 0, 1, NONE, 0, "R5");

    doReset();  // R5 output outside burst, R7 freeze
    step(8'h04, 8'h00, 0, 0, 2, 1, 0, 0, 0, "R2");
    step(8'h04, 8'h01, 1, 2, 2, 1, 1, 2, 1, "R5");
    step(8'h04, 8'h07, 1, 2, 2, 1, 1, 2, 1, "R7");

    doReset();  // R6 input while output pending
    step(8'h03, 8'h00, 0, 0, 1, 1, 0, 0, 0, "R2");
    step(8'h02, 8'h00, 1, 3, 1, 1, 1, 0, 1, "R6");

    doReset();  // R6 input in the sample the last output lands, R10 priority
    step(8'h03, 8'h00, 0, 0, 1, 1, 0, 0, 0, "R2");
    step(8'h02, 8'h01, 1, 3, 1, 1, 1, 0, 1, "R6");

    doReset();  // R5 output in the completing sample
    step(8'h03, 8'h01, 1, 2, 0, 0, 1, NONE, 0, "R5");

    doReset();  // R10 stray input beats stray output
    step(8'h10, 8'h01, 1, 1, 0, 0, 1, NONE, 0, "R10");

    doReset();  // R8 cycle count
    step(8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(8'h40, 8'h00, 1, 1, 0, 0, 1, NONE, 3, "R8");

    doReset();  // R8 last arc index
    step(8'h03, 8'h00, 0, 0, 1, 1, 0, 0, 0, "R2");
    step(8'h03, 8'h01, 0, 0, 1, 0, 0, 0, 0, "R3");
    step(8'h0B, 8'h01, 0, 0, 3, 0, 0, 0, 0, "R3");
    step(8'h0A, 8'h01, 0, 0, 3, 0, 0, 0, 0, "R2");
    step(8'h0E, 8'h01, 1, 1, 3, 0, 1, 4, 4, "R8");

    wait (expQ.size() == 0);
    @(negedge clk);
    finishRun();
  end

endmodule